// File: doc/BRIEF.md
# Collision-Vector Issue Controller

This block decides, one cycle at a time, whether a new operation may enter a non-linear pipeline whose stages share a single hardware resource, so that no two operations in flight ever need the same stage in the same cycle. It keeps a state vector of width `M`. A 1 at position k (k counted from 1 at the least significant end) means that starting an operation k cycles from now would collide with work already in flight.

The forbidden latencies of a single operation are fixed at build time by the parameter `INIT_CV`, which is worked out beforehand from the pipeline's usage table. A requester holds `req` high until it sees `grant`. The grant is decided in the same cycle, so requests are served at the earliest latency that is free, which gives a greedy schedule. The block also shows its state vector and the number of cycles since the last issue.

Top module: `cv_issue_ctrl`

## Requirements
- R1: After synchronous reset the state vector is all zeros and the since-issue count reads its saturated maximum (all ones). A request in the first cycle after reset is granted in that same cycle.
- R2: `grant` is high in a cycle exactly when `req` is high and bit 0 of `state_o` is 0. The grant is combinational, with no register between `req` and `grant`.
- R3: In a cycle without a grant, the next `state_o` is the current one shifted right by one position, with 0 entering at bit M-1.
- R4: In a cycle with a grant, the next `state_o` is the right-shifted current state ORed with `INIT_CV`. With the default vector 1011010, an issue 3 cycles after an issue from the initial state yields 1011011.
- R5: A refused request is served at the first cycle whose bit 0 is free. With the default vector and `req` held high continuously from reset, grants occur at offsets 0, 1, 9, 10, 18, 19, which is the repeating latency pair (1, 8).
- R6: With the default vector, issuing every 3 cycles is granted every time, and the state holds at 1011011.
- R7: With the default vector, the forbidden latencies are 2, 4, 5 and 7. A request held from one of these latencies after a single issue is granted at latency 3, 6, 6 or 8 respectively.
- R8: After an idle gap longer than M cycles, an issue leaves the state exactly equal to `INIT_CV`.
- R9: `since_issue_o` reads 1 in the cycle after a grant. It increments by one each cycle without a grant, and it saturates at its all-ones value.
- R10: With M = 4 and vector 1010, latencies 1 and 3 are granted, while 2 and 4 are refused. A request held from latency 2 is granted at latency 3, and one held from latency 4 is granted at latency 5.
- R11: No sequence of grants puts two operations in the same stage (A at offsets 0, 5 and 7, B at offsets 1 and 3, C at offsets 2, 4 and 6) in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request to start a new operation |
| grant | output | 1 | Operation admitted this cycle |
| state_o | output | M | Current collision state vector |
| since_issue_o | output | CNT_W | Cycles since the last grant, saturating |

## Verification
`grant` is combinational, so it is due in the same cycle that `req` is driven. `state_o` and `since_issue_o` change at the next rising edge. The bench drives `req` just after a falling edge and reads `grant` one time unit later, inside that same cycle. It reads the registered outputs at the following falling edge, one edge after the decision that produced them. Expected grant offsets, state vectors and count values are all derived from the latency rules, and independently of these, a stage-occupancy model checks that the logged grant times never collide.

// File: rtl/cv_pkg.sv
package cv_pkg;

    // What the state register does on a given cycle
    typedef enum logic [0:0] {
        CV_SHIFT = 1'b0,
        CV_ISSUE = 1'b1
    } cv_act_e;

    // Outcome of the admission decision
    typedef struct packed {
        logic    grant;
        logic    blocked;
        cv_act_e act;
    } cv_dec_t;

    // Upper bound on vector width supported by the parameter encoding
    localparam int CV_MAX_W = 64;

endpackage

// File: rtl/cv_issue_gate.sv
module cv_issue_gate
    import cv_pkg::*;
(
    input  logic    req,
    input  logic    head_busy,
    output cv_dec_t dec
);
    always_comb begin
        dec.blocked = head_busy;
        dec.grant   = req && !head_busy;
        dec.act     = dec.grant ? CV_ISSUE : CV_SHIFT;
    end
endmodule

// File: rtl/cv_state_reg.sv
module cv_state_reg
    import cv_pkg::*;
#(
    parameter int            M       = 7,
    parameter logic [M-1:0]  CV_INIT = 7'b1011010
) (
    input  logic         clk,
    input  logic         rst,
    input  cv_act_e      act,
    output logic [M-1:0] state_q
);
    logic [M-1:0] shifted;
    logic [M-1:0] state_d;

    always_comb begin
        shifted = state_q >> 1;
        unique case (act)
            CV_ISSUE: state_d = shifted | CV_INIT;
            default:  state_d = shifted;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/cv_since_counter.sv
module cv_since_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue,
    output logic [CNT_W-1:0] count_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst)                    count_q <= CNT_MAX;
        else if (issue)             count_q <= CNT_ONE;
        else if (count_q != CNT_MAX) count_q <= count_q + CNT_ONE;
    end
endmodule

// File: rtl/cv_issue_ctrl.sv
module cv_issue_ctrl
    import cv_pkg::*;
#(
    parameter int          M       = 7,
    parameter logic [63:0] INIT_CV = 64'b1011010,
    parameter int          CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    output logic             grant,
    output logic [M-1:0]     state_o,
    output logic [CNT_W-1:0] since_issue_o
);
    localparam logic [M-1:0] CV0 = INIT_CV[M-1:0];

    // Parameter sanity: width in range, top bit set, nothing above it
    generate
        if (M < 1 || M > CV_MAX_W) begin : g_bad_width
            $error("cv_issue_ctrl: vector width out of range");
        end else if (INIT_CV[M-1] != 1'b1) begin : g_bad_top
            $error("cv_issue_ctrl: initial vector must have its top bit set");
        end else if (M < CV_MAX_W && (INIT_CV >> M) != 64'd0) begin : g_bad_fit
            $error("cv_issue_ctrl: initial vector wider than M");
        end
    endgenerate

    cv_dec_t      dec;
    logic [M-1:0] state_q;

    cv_issue_gate u_gate (
        .req       (req),
        .head_busy (state_q[0]),
        .dec       (dec)
    );

    cv_state_reg #(.M(M), .CV_INIT(CV0)) u_state (
        .clk     (clk),
        .rst     (rst),
        .act     (dec.act),
        .state_q (state_q)
    );

    cv_since_counter #(.CNT_W(CNT_W)) u_since (
        .clk     (clk),
        .rst     (rst),
        .issue   (dec.grant),
        .count_q (since_issue_o)
    );

    assign grant   = dec.grant;
    assign state_o = state_q;
endmodule

// File: rtl/cv_issue_ctrl_chk.sv
module cv_issue_ctrl_chk #(
    parameter int          M       = 7,
    parameter logic [63:0] INIT_CV = 64'b1011010,
    parameter int          CNT_W   = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             req,
    input logic             grant,
    input logic [M-1:0]     state_o,
    input logic [CNT_W-1:0] since_issue_o
);
    localparam logic [M-1:0]     CV0     = INIT_CV[M-1:0];
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Is latency k (1..M) forbidden by the initial vector?
    function automatic logic lat_forbidden(input logic [CNT_W-1:0] k);
        logic r;
        r = 1'b0;
        for (int i = 1; i <= M; i++)
            if (int'(k) == i) r = CV0[i-1];
        return r;
    endfunction

    // R2: a grant needs a request; a refusal needs a busy head bit
    assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
        grant |-> req);
    assert_refuse_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (req && !grant) |-> state_o[0]);

    // R3: idle cycle shifts
    assert_idle_shift_R3: assert property (@(posedge clk) disable iff (rst)
        !grant |=> state_o == ($past(state_o) >> 1));

    // R4: issue merges the initial vector
    assert_issue_merge_R4: assert property (@(posedge clk) disable iff (rst)
        grant |=> state_o == (($past(state_o) >> 1) | CV0));

    // R7 / R11: a grant never lands on a forbidden latency after the last one
    assert_no_forbidden_R7: assert property (@(posedge clk) disable iff (rst)
        grant |-> !lat_forbidden(since_issue_o));

    // R9: count restarts at one and counts up to saturation
    assert_count_restart_R9: assert property (@(posedge clk) disable iff (rst)
        grant |=> since_issue_o == CNT_W'(1));
    assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
        (!grant && since_issue_o != CNT_MAX) |=> since_issue_o == $past(since_issue_o) + CNT_W'(1));
    assert_count_sat_R9: assert property (@(posedge clk) disable iff (rst)
        (!grant && since_issue_o == CNT_MAX) |=> since_issue_o == CNT_MAX);
endmodule

bind cv_issue_ctrl cv_issue_ctrl_chk #(.M(M), .INIT_CV(INIT_CV), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req           (req),
    .grant         (grant),
    .state_o       (state_o),
    .since_issue_o (since_issue_o)
);

// File: tb/cv_issue_ctrl_tb.sv
module cv_issue_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic       req4 = 1'b0;
    logic       grant, grant4;
    logic [6:0] state7;
    logic [3:0] state4;
    logic [3:0] since7, since4;

    localparam logic [6:0] ICV7 = 7'b1011010;
    localparam logic [3:0] ICV4 = 4'b1010;

    int n_chk = 0;
    int n_bad = 0;
    int tnow  = 0;
    int glog [256];
    int nlog  = 0;
    logic g7, g4;

    always #4 clk = ~clk;   // 125 MHz

    cv_issue_ctrl u_dut (
        .clk(clk), .rst(rst), .req(req), .grant(grant),
        .state_o(state7), .since_issue_o(since7)
    );

    cv_issue_ctrl #(.M(4), .INIT_CV(64'b1010), .CNT_W(4)) u_dut_m4 (
        .clk(clk), .rst(rst), .req(req4), .grant(grant4),
        .state_o(state4), .since_issue_o(since4)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called just after a falling edge; returns just after the next one.
    task automatic tick(input logic r, input logic r4);
        req  = r;
        req4 = r4;
        #1;
        g7 = grant;
        g4 = grant4;
        if (g7 && nlog < 256) begin
            glog[nlog] = tnow;
            nlog++;
        end
        @(negedge clk);
        tnow++;
    endtask

    task automatic do_reset();
        req = 1'b0; req4 = 1'b0; rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        nlog = 0;
        tnow = 0;
    endtask

    function automatic int stage_of(input int o);
        case (o)
            0, 5, 7: return 0;   // A
            1, 3:    return 1;   // B
            default: return 2;   // C
        endcase
    endfunction

    task automatic check_no_collision(input string tag);
        int hits = 0;
        for (int i = 0; i < nlog; i++)
            for (int j = i + 1; j < nlog; j++) begin
                int d = glog[j] - glog[i];
                if (d < 8)
                    for (int o = 0; o + d < 8; o++)
                        if (stage_of(o) == stage_of(o + d)) hits++;
            end
        check(tag, hits, 0);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 state zero after reset", state7, 0);
        check("R1 count saturated after reset", since7, 4'hF);
        tick(1'b1, 1'b0);
        check("R1 first request granted", g7, 1);
        check("R4 state loads initial vector", state7, ICV7);
    endtask

    task automatic t_greedy_continuous();
        do_reset();
        for (int i = 0; i < 20; i++) begin
            logic e = (i == 0 || i == 1 || i == 9 || i == 10 || i == 18 || i == 19);
            tick(1'b1, 1'b0);
            check($sformatf("R5 greedy grant offset %0d", i), g7, e);
        end
        check_no_collision("R11 greedy (1,8) no collision");
    endtask

    task automatic t_latency3();
        do_reset();
        tick(1'b1, 1'b0);
        for (int k = 1; k <= 4; k++) begin
            tick(1'b0, 1'b0);
            tick(1'b0, 1'b0);
            tick(1'b1, 1'b0);
            check($sformatf("R6 latency-3 issue %0d granted", k), g7, 1);
            check($sformatf("R4 R6 state after issue %0d", k), state7, 7'b1011011);
        end
        check_no_collision("R11 latency-3 no collision");
    endtask

    task automatic t_forbidden(input int start, input int exp_lat);
        int lat;
        do_reset();
        tick(1'b1, 1'b0);
        if (start == 2) begin
            check("R3 state one cycle after issue", state7, ICV7);
            tick(1'b0, 1'b0);
            check("R3 state shifted once", state7, ICV7 >> 1);
        end else begin
            for (int i = 1; i < start; i++) tick(1'b0, 1'b0);
        end
        lat = start;
        tick(1'b1, 1'b0);
        while (!g7 && lat < 12) begin
            lat++;
            tick(1'b1, 1'b0);
        end
        check($sformatf("R7 request from latency %0d granted at", start), lat, exp_lat);
    endtask

    task automatic t_long_gap();
        do_reset();
        tick(1'b1, 1'b0);
        check("R9 count one after grant", since7, 1);
        for (int n = 1; n <= 20; n++) begin
            tick(1'b0, 1'b0);
            check($sformatf("R9 count after %0d idle", n), since7, (n + 1 > 15) ? 15 : n + 1);
        end
        tick(1'b1, 1'b0);
        check("R8 grant after long gap", g7, 1);
        check("R8 state equals initial vector", state7, ICV7);
    endtask

    task automatic t_m4();
        int lat;
        // latency 1 allowed
        do_reset();
        tick(1'b0, 1'b1);
        check("R10 m4 first grant", g4, 1);
        check("R10 m4 state loads vector", state4, ICV4);
        tick(1'b0, 1'b1);
        check("R10 m4 latency 1 granted", g4, 1);
        // held from latency 2
        do_reset();
        tick(1'b0, 1'b1);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b1);
        check("R10 m4 latency 2 refused", g4, 0);
        tick(1'b0, 1'b1);
        check("R10 m4 granted at latency 3", g4, 1);
        // held from latency 4
        do_reset();
        tick(1'b0, 1'b1);
        for (int i = 1; i < 4; i++) tick(1'b0, 1'b0);
        lat = 4;
        tick(1'b0, 1'b1);
        check("R10 m4 latency 4 refused", g4, 0);
        while (!g4 && lat < 10) begin
            lat++;
            tick(1'b0, 1'b1);
        end
        check("R10 m4 held from 4 granted at", lat, 5);
    endtask

    task automatic t_pseudo_random();
        logic [7:0] lf = 8'hA5;
        do_reset();
        for (int i = 0; i < 150; i++) begin
            logic head = state7[0];
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            tick(lf[0], 1'b0);
            check($sformatf("R2 grant rule cycle %0d", i), g7, lf[0] && !head);
        end
        check_no_collision("R11 pseudo-random no collision");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_greedy_continuous();
        t_latency3();
        t_forbidden(2, 3);
        t_forbidden(4, 6);
        t_forbidden(5, 6);
        t_forbidden(7, 8);
        t_long_gap();
        t_m4();
        t_pseudo_random();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule